// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block executes the three data-manipulating instructions of a small 16-bit load/store machine: two's-complement addition, bitwise AND and bitwise complement. It owns an eight-entry file of 16-bit general registers and a three-bit condition state made of negative, zero and positive indicators. When a valid strobe comes with an instruction word, the block decodes it, reads its sources, computes the result and writes it to the destination register. The condition state is updated at the same clock edge.

For addition and AND, bit 5 selects the second operand. It is either a second register or a 5-bit signed constant embedded in the word. Words that are not well-formed operate instructions leave all state untouched. A combinational read port lets the surrounding pipeline, or a bench, observe any register.

Top module: `op_unit`

## Requirements
- R1: After reset, every register reads 0 and the condition outputs are n=0, z=1, p=0.
- R2: With instr_valid high, opcode bits [15:12]=0001 (add), bit 5=0 and bits [4:3]=00, the register named by [11:9] receives the sum, modulo 2^16, of the registers named by [8:6] and [2:0].
- R3: With bit 5=1, add and AND use bits [4:0] as a two's-complement constant sign-extended to 16 bits in place of the second register.
- R4: Opcode 0101 writes the bitwise AND of its two operands, which are chosen as in R2/R3, to the register named by [11:9].
- R5: Opcode 1001 with bits [5:0]=111111 writes the bitwise complement of the register named by [8:6] to the register named by [11:9].
- R6: Each register write sets exactly one of n, z, p from the value written (bit 15 set: n; all zero: z; otherwise p), visible after the same clock edge as the write.
- R7: A word with any other opcode, a complement word whose bits [5:0] are not all ones, a register-mode add/AND word with bits [4:3] not 00, or any cycle with instr_valid low, changes neither registers nor flags.
- R8: A source register that is also the destination supplies its value from before the write.
- R9: rd_data shows the register selected by rd_sel combinationally.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| rd_sel | input | 3 | Register index for the observation port |
| rd_data | output | 16 | Contents of the selected register |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
A bad register entry or a bad flag value shows up at the ports one clock after the instruction that caused it. The flags move at that edge, and rd_data shows the destination as soon as rd_sel selects it. A malformed word that reaches the write enable is seen as a changed flag or a changed register in the next cycle. A decode that swaps register fields corrupts a register other than the one expected, and later results that read it expose the fault.

// File: rtl/op_pkg.sv
package op_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_INV = 2'd2
  } alu_fn_e;
endpackage

// File: rtl/op_decode.sv
module op_decode
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned IMM_W  = 5
) (
  input  logic               valid,
  input  logic [INSTR_W-1:0] word,
  output logic               wr_en,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [IDX_W-1:0]   src_a_idx,
  output logic [IDX_W-1:0]   src_b_idx,
  output logic               use_imm,
  output logic [DATA_W-1:0]  imm_ext,
  output alu_fn_e            fn
);
  logic [3:0] opc;
  logic       reg_form_ok;
  logic       inv_form_ok;

  assign opc       = word[15:12];
  assign dst_idx   = word[11:9];
  assign src_a_idx = word[8:6];
  assign src_b_idx = word[2:0];
  assign use_imm   = word[5];
  assign imm_ext   = {{(DATA_W-IMM_W){word[IMM_W-1]}}, word[IMM_W-1:0]};

  assign reg_form_ok = word[5] | (word[4:3] == 2'b00);
  assign inv_form_ok = (word[5:0] == 6'b111111);

  always_comb begin
    fn    = FN_ADD;
    wr_en = 1'b0;
    unique case (opc)
      OPC_ADD: begin
        fn    = FN_ADD;
        wr_en = valid & reg_form_ok;
      end
      OPC_AND: begin
        fn    = FN_AND;
        wr_en = valid & reg_form_ok;
      end
      OPC_NOT: begin
        fn    = FN_INV;
        wr_en = valid & inv_form_ok;
      end
      default: begin
        fn    = FN_ADD;
        wr_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/op_alu.sv
module op_alu
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (fn)
      FN_ADD:  res = opa + opb;
      FN_AND:  res = opa & opb;
      FN_INV:  res = ~opa;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/op_regfile.sv
module op_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_N  = 8,
  localparam int unsigned IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic [IDX_W-1:0]  ra_b,
  output logic [DATA_W-1:0] rd_b,
  input  logic [IDX_W-1:0]  ra_c,
  output logic [DATA_W-1:0] rd_c
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic load_en;
    assign load_en = we & (wa == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (load_en) begin
        regs_q[g] <= wd;
      end
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];
  assign rd_c = regs_q[ra_c];
endmodule

// File: rtl/op_flags.sv
module op_flags #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] value,
  output logic              n_q,
  output logic              z_q,
  output logic              p_q
);
  logic n_d, z_d, p_d;

  always_comb begin
    z_d = (value == '0);
    n_d = value[DATA_W-1];
    p_d = ~z_d & ~n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b1;
      p_q <= 1'b0;
    end else if (upd_en) begin
      n_q <= n_d;
      z_q <= z_d;
      p_q <= p_d;
    end
  end
endmodule

// File: rtl/op_unit.sv
module op_unit
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_N  = 8,
  parameter int unsigned IMM_W  = 5,
  localparam int unsigned IDX_W = $clog2(REG_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_p
);
  logic              rst_meta_q, rst_sync_n;
  logic              wr_en, use_imm;
  logic [IDX_W-1:0]  dst_idx, src_a_idx, src_b_idx;
  logic [DATA_W-1:0] imm_ext, opa, reg_b, opb, wr_data;
  alu_fn_e           fn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  op_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
    .valid     (instr_valid),
    .word      (instr),
    .wr_en     (wr_en),
    .dst_idx   (dst_idx),
    .src_a_idx (src_a_idx),
    .src_b_idx (src_b_idx),
    .use_imm   (use_imm),
    .imm_ext   (imm_ext),
    .fn        (fn)
  );

  op_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_en),
    .wa    (dst_idx),
    .wd    (wr_data),
    .ra_a  (src_a_idx),
    .rd_a  (opa),
    .ra_b  (src_b_idx),
    .rd_b  (reg_b),
    .ra_c  (rd_sel),
    .rd_c  (rd_data)
  );

  assign opb = use_imm ? imm_ext : reg_b;

  op_alu #(.DATA_W(DATA_W)) u_alu (
    .fn  (fn),
    .opa (opa),
    .opb (opb),
    .res (wr_data)
  );

  op_flags #(.DATA_W(DATA_W)) u_cc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (wr_en),
    .value  (wr_data),
    .n_q    (flag_n),
    .z_q    (flag_z),
    .p_q    (flag_p)
  );
endmodule

// File: rtl/op_unit_chk.sv
module op_unit_chk
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               flag_n,
  input logic               flag_z,
  input logic               flag_p,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data
);
  logic known_op;
  assign known_op = (instr[15:12] == OPC_ADD) || (instr[15:12] == OPC_AND) ||
                    (instr[15:12] == OPC_NOT);

  AST_FLAGS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({flag_n, flag_z, flag_p}) == 1); // R6

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |=> $stable({flag_n, flag_z, flag_p})); // R7

  AST_FOREIGN_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && !known_op) |=> $stable({flag_n, flag_z, flag_p})); // R7

  AST_BAD_INV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr[15:12] == OPC_NOT && instr[5:0] != 6'b111111) |-> !wr_en); // R5

  AST_ZERO_SETS_Z: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_data == '0) |=> flag_z); // R6

  AST_SIGN_SETS_N: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_data[DATA_W-1]) |=> flag_n); // R6
endmodule

bind op_unit op_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_p      (flag_p),
  .wr_en       (wr_en),
  .wr_data     (wr_data)
);

// File: tb/op_unit_test.sv
module op_unit_test;
  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;
  logic        flag_n, flag_z, flag_p;
  int          total, bad;
  bit          done;

  op_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {instr, dst, value, nzp}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {16'h1225, 3'd1, 16'h0005, 3'b001},  // R3 add imm +5
    {16'h1470, 3'd2, 16'hFFF5, 3'b100},  // R3 add imm -16 sign-extended
    {16'h1642, 3'd3, 16'hFFFA, 3'b100},  // R2 add register
    {16'h58EF, 3'd4, 16'h000A, 3'b001},  // R4 and imm
    {16'h9B3F, 3'd5, 16'hFFF5, 3'b100},  // R5 complement
    {16'h5D44, 3'd6, 16'h0000, 3'b010},  // R4 and register, R6 zero
    {16'h1F6F, 3'd7, 16'h0004, 3'b001},  // R2 wrap to small positive
    {16'h16C3, 3'd3, 16'hFFF4, 3'b100},  // R8 src equals dst
    {16'h127B, 3'd1, 16'h0000, 3'b010},  // R2 wrap to zero
    {16'h903F, 3'd0, 16'hFFFF, 3'b100},  // R5 complement of zero
    {16'h1021, 3'd0, 16'h0000, 3'b010}   // R2 FFFF+1 wraps
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr = w;
    instr_valid = v;
    @(negedge clk);
    instr_valid = 1'b0;
    instr = 16'h0000;
  endtask

  task automatic peek(input logic [2:0] idx, output logic [15:0] val);
    rd_sel = idx;
    #1;
    val = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    logic [2:0]  f;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; rd_sel = '0;
    #9 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 flags", {13'd0, flag_n, flag_z, flag_p}, 16'd2);
    for (int i = 0; i < 8; i++) begin
      peek(3'(i), v);
      chk("R1 reg", v, 16'h0000);
    end

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][37:22], 1'b1);
      peek(VEC[k][21:19], v);
      chk("R2/R3/R4/R5/R8 R9 value", v, VEC[k][18:3]);
      f = {flag_n, flag_z, flag_p};
      chk("R6 flags", {13'd0, f}, {13'd0, VEC[k][2:0]});
    end

    // set a positive flag state: ADD R1,R1,#3 -> 3
    issue(16'h1263, 1'b1);
    chk("R6 positive", {13'd0, flag_n, flag_z, flag_p}, 16'd1);

    // R7: foreign opcode naming R1 as destination
    issue(16'h2222, 1'b1);
    peek(3'd1, v);
    chk("R7 foreign opcode reg", v, 16'h0003);
    chk("R7 foreign opcode flags", {13'd0, flag_n, flag_z, flag_p}, 16'd1);

    // R7: malformed complement targeting R1
    issue(16'h927E, 1'b1);
    peek(3'd1, v);
    chk("R7 R5 bad complement", v, 16'h0003);
    chk("R7 bad complement flags", {13'd0, flag_n, flag_z, flag_p}, 16'd1);

    // R7: register-mode add with bits [4:3] nonzero, dst R1
    issue(16'h1248, 1'b1);
    peek(3'd1, v);
    chk("R7 bad reg form", v, 16'h0003);

    // R7: valid low, AND R1,R1,#0 would clear
    issue(16'h5260, 1'b0);
    peek(3'd1, v);
    chk("R7 valid low reg", v, 16'h0003);
    chk("R7 valid low flags", {13'd0, flag_n, flag_z, flag_p}, 16'd1);

    // R3: immediate -1 sign extension: AND R2,R7,#-1 -> 0004
    issue(16'h55FF, 1'b1);
    peek(3'd2, v);
    chk("R3 imm -1", v, 16'h0004);

    // R9: observation port follows rd_sel without a clock
    peek(3'd5, v);
    chk("R9 read R5", v, 16'hFFF5);
    peek(3'd3, v);
    chk("R9 read R3", v, 16'hFFF4);

    // R1: reset again clears state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    peek(3'd3, v);
    chk("R1 reg after reset", v, 16'h0000);
    chk("R1 flags after reset", {13'd0, flag_n, flag_z, flag_p}, 16'd2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule